// File: doc/BRIEF.md
# Receive FIFO with Automatic Request-to-Send

This block stores incoming serial characters between the receive shift register and the host. Each stored word holds eight data bits and three error bits. The host reads the words back in arrival order. A level interrupt tells the host when enough characters are waiting.

The block also drives an active-low request-to-send output, `rts_n`, which the remote transmitter watches. In automatic mode the output goes high to pause the remote side when the buffer is nearly full. It goes low again only after the buffer has drained well below that point, so the two thresholds give the output hysteresis. Each rising edge of `rts_n` can latch a status flag for the interrupt logic. The host clears that flag by reading the interrupt status.

All thresholds come from parameters. With a receive trigger of `RX_TRIG` = 16 and `DEPTH` = 64, the pause point is a fill above 56 and the resume point is a fill below 8.

Top module: `rx_fifo_autorts`

## Requirements
- R1: The FIFO holds 64 words of 11 bits and returns them in write order. The word on `rd_data` is laid out as data in bits 7:0, parity error in bit 8, framing error in bit 9 and break in bit 10, the same layout as `{wr_err, wr_data}`. `rd_data` is updated at the clock edge that samples `rd_en`.
- R2: While `fifo_en` is 0 the FIFO is emptied and writes are ignored. After `fifo_en` returns to 1, a read finds the FIFO empty.
- R3: A write strobe that arrives while 64 words are stored is dropped. It sets `overrun`, which stays high until `fifo_en` is 0 or reset is applied. The stored words are not changed.
- R4: A read strobe on an empty FIFO leaves `rd_data` and both pointers unchanged, so the next word written is the next word read.
- R5: `trig_irq` is high exactly while `fifo_en` is 1 and the fill is at least `RX_TRIG` (16). It changes at the same edge as the fill.
- R6: Unless both `auto_rts_en` and `rts_req` are 1, `rts_n` is registered as the inverse of `rts_req` at every edge.
- R7: With both `auto_rts_en` and `rts_req` at 1, `rts_n` goes high at the edge where the fill becomes greater than 56. A fill of exactly 56 does not change it.
- R8: In automatic mode, `rts_n` goes low at the edge where the fill becomes less than 8. For fills from 8 to 56 it keeps its previous value.
- R9: A rising edge of `rts_n` sets `rts_flag` only when `enh_en` and `rts_int_en` are both 1 at that edge. If either is 0, `rts_flag` stays 0.
- R10: A pulse on `isr_rd` clears `rts_flag`. If a new rising edge of `rts_n` occurs at the same edge, the flag is set instead.
- R11: After reset, `rts_n` is 1, `rts_flag`, `overrun` and `trig_irq` are 0, `rd_data` is 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable; 0 flushes the FIFO |
| wr_en | input | 1 | Write strobe from the receive shift register |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error bits: [0] parity, [1] framing, [2] break |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 11 | Last word read: {break, framing, parity, data} |
| auto_rts_en | input | 1 | Automatic request-to-send enable |
| rts_req | input | 1 | Host request-to-send bit |
| enh_en | input | 1 | Extended interrupt enable gate |
| rts_int_en | input | 1 | Request-to-send interrupt enable |
| isr_rd | input | 1 | Interrupt status read pulse; clears `rts_flag` |
| rts_n | output | 1 | Active-low request-to-send to the remote side |
| trig_irq | output | 1 | Receive trigger-level interrupt |
| rts_flag | output | 1 | Sticky flag for a rising edge of `rts_n` |
| overrun | output | 1 | Sticky flag for a write dropped while full |

## Verification
Every result is due one clock edge after its stimulus:
- `rd_data` changes at the edge that samples `rd_en`.
- The fill, `trig_irq` and `overrun` change at the edge that samples the strobe that moves them.
- `rts_n` and `rts_flag` are computed from the next fill, so they change at the same edge as the fill itself.

The bench drives each stimulus just after a falling edge. It then waits for one rising edge and samples at the following falling edge, so each check reads the value due exactly one cycle later. The pause and resume points are approached one word at a time, and the bench checks `rts_n` on both sides of each threshold.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_word_t;

    localparam int WORD_W = $bits(rx_word_t);

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_en,
    input  logic                         wr_en,
    input  rxf_pkg::rx_word_t            wr_word,
    input  logic                         rd_en,
    output rxf_pkg::rx_word_t            rd_word,
    output logic [$clog2(DEPTH+1)-1:0]   fill_q,
    output logic [$clog2(DEPTH+1)-1:0]   fill_d,
    output logic                         ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     cnt;
        rxf_pkg::rx_word_t rdata;
        logic              ovr;
    } store_t;

    store_t            st_d, st_q;
    rxf_pkg::rx_word_t mem [DEPTH];
    logic              do_wr, do_rd;

    always_comb begin
        st_d  = st_q;
        do_wr = 1'b0;
        do_rd = 1'b0;
        if (!fifo_en) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
            st_d.ovr  = 1'b0;
        end else begin
            do_wr = wr_en && (st_q.cnt != FULL_CNT);
            do_rd = rd_en && (st_q.cnt != '0);
            if (wr_en && (st_q.cnt == FULL_CNT)) begin
                st_d.ovr = 1'b1;
            end
            if (do_wr) begin
                st_d.wptr = st_q.wptr + 1'b1;
            end
            if (do_rd) begin
                st_d.rdata = mem[st_q.rptr];
                st_d.rptr  = st_q.rptr + 1'b1;
            end
            st_d.cnt = st_q.cnt + {{(CW-1){1'b0}}, do_wr} - {{(CW-1){1'b0}}, do_rd};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[st_q.wptr] <= wr_word;
        end
    end

    assign rd_word = st_q.rdata;
    assign fill_q  = st_q.cnt;
    assign fill_d  = st_d.cnt;
    assign ovr     = st_q.ovr;

endmodule

// File: rtl/rxf_flow.sv
module rxf_flow #(
    parameter int CW         = 7,
    parameter int PAUSE_LVL  = 56,
    parameter int RESUME_LVL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_en,
    input  logic          rts_req,
    input  logic          enh_en,
    input  logic          rts_int_en,
    input  logic          isr_rd,
    input  logic [CW-1:0] fill_next,
    output logic          rts_n,
    output logic          rts_flag
);
    localparam logic [CW-1:0] PAUSE_C  = CW'(PAUSE_LVL);
    localparam logic [CW-1:0] RESUME_C = CW'(RESUME_LVL);

    typedef struct packed {
        logic rts_n;
        logic flag;
    } flow_t;

    flow_t flow_d, flow_q;
    logic  auto_on;
    logic  rise;

    always_comb begin
        flow_d  = flow_q;
        auto_on = auto_en && rts_req;
        if (!auto_on) begin
            flow_d.rts_n = !rts_req;
        end else if (fill_next > PAUSE_C) begin
            flow_d.rts_n = 1'b1;
        end else if (fill_next < RESUME_C) begin
            flow_d.rts_n = 1'b0;
        end
        rise = flow_d.rts_n && !flow_q.rts_n;
        if (isr_rd) begin
            flow_d.flag = 1'b0;
        end
        if (rise && enh_en && rts_int_en) begin
            flow_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_q <= '{rts_n: 1'b1, flag: 1'b0};
        end else begin
            flow_q <= flow_d;
        end
    end

    assign rts_n    = flow_q.rts_n;
    assign rts_flag = flow_q.flag;

endmodule

// File: rtl/rx_fifo_autorts.sv
module rx_fifo_autorts #(
    parameter int DEPTH   = 64,
    parameter int RX_TRIG = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_en,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  wr_err,
    input  logic        rd_en,
    output logic [10:0] rd_data,
    input  logic        auto_rts_en,
    input  logic        rts_req,
    input  logic        enh_en,
    input  logic        rts_int_en,
    input  logic        isr_rd,
    output logic        rts_n,
    output logic        trig_irq,
    output logic        rts_flag,
    output logic        overrun
);
    localparam int CW         = $clog2(DEPTH + 1);
    localparam int RESUME_LVL = RX_TRIG / 2;
    localparam int PAUSE_LVL  = DEPTH - RESUME_LVL;
    localparam logic [CW-1:0] TRIG_C = CW'(RX_TRIG);

    rxf_pkg::rx_word_t wr_word, rd_word;
    logic [CW-1:0]     fill_q, fill_d;

    assign wr_word = '{brk: wr_err[2], frm: wr_err[1], par: wr_err[0], data: wr_data};

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .fill_q  (fill_q),
        .fill_d  (fill_d),
        .ovr     (overrun)
    );

    rxf_flow #(
        .CW         (CW),
        .PAUSE_LVL  (PAUSE_LVL),
        .RESUME_LVL (RESUME_LVL)
    ) u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_rts_en),
        .rts_req    (rts_req),
        .enh_en     (enh_en),
        .rts_int_en (rts_int_en),
        .isr_rd     (isr_rd),
        .fill_next  (fill_d),
        .rts_n      (rts_n),
        .rts_flag   (rts_flag)
    );

    assign rd_data  = rd_word;
    assign trig_irq = fifo_en && (fill_q >= TRIG_C);

endmodule

// File: rtl/rx_fifo_autorts_chk.sv
module rx_fifo_autorts_chk #(
    parameter int DEPTH      = 64,
    parameter int CW         = 7,
    parameter int PAUSE_LVL  = 56,
    parameter int RESUME_LVL = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          wr_en,
    input logic          auto_rts_en,
    input logic          rts_req,
    input logic          enh_en,
    input logic          rts_int_en,
    input logic [CW-1:0] fill,
    input logic          rts_n,
    input logic          rts_flag,
    input logic          overrun
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R1

    AST_FLUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> (fill == '0)); // R2

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && wr_en && fill == CW'(DEPTH)) |=> (overrun && fill == CW'(DEPTH))); // R3

    AST_MANUAL_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        !(auto_rts_en && rts_req) |=> (rts_n == !$past(rts_req))); // R6

    AST_PAUSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rts_req) |=> (fill <= CW'(PAUSE_LVL) || rts_n)); // R7

    AST_RESUME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rts_req) |=> (fill >= CW'(RESUME_LVL) || !rts_n)); // R8

    AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_n) && $past(enh_en && rts_int_en)) |-> rts_flag); // R9

    AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_flag) |-> $past(enh_en && rts_int_en)); // R9

endmodule

bind rx_fifo_autorts rx_fifo_autorts_chk #(
    .DEPTH      (DEPTH),
    .CW         (CW),
    .PAUSE_LVL  (PAUSE_LVL),
    .RESUME_LVL (RESUME_LVL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .wr_en       (wr_en),
    .auto_rts_en (auto_rts_en),
    .rts_req     (rts_req),
    .enh_en      (enh_en),
    .rts_int_en  (rts_int_en),
    .fill        (fill_q),
    .rts_n       (rts_n),
    .rts_flag    (rts_flag),
    .overrun     (overrun)
);

// File: tb/rx_fifo_autorts_tb.sv
module rx_fifo_autorts_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  wr_err = '0;
    logic        rd_en = 1'b0;
    logic [10:0] rd_data;
    logic        auto_rts_en = 1'b0;
    logic        rts_req = 1'b0;
    logic        enh_en = 1'b0;
    logic        rts_int_en = 1'b0;
    logic        isr_rd = 1'b0;
    logic        rts_n, trig_irq, rts_flag, overrun;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rx_fifo_autorts u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_en(wr_en),
        .wr_data(wr_data), .wr_err(wr_err), .rd_en(rd_en), .rd_data(rd_data),
        .auto_rts_en(auto_rts_en), .rts_req(rts_req), .enh_en(enh_en),
        .rts_int_en(rts_int_en), .isr_rd(isr_rd), .rts_n(rts_n),
        .trig_irq(trig_irq), .rts_flag(rts_flag), .overrun(overrun)
    );

    // {auto_rts_en, rts_req, expected rts_n, word written}
    localparam int NV = 6;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 11'h0A5},
        {1'b0, 1'b0, 1'b1, 11'h15A},
        {1'b1, 1'b0, 1'b1, 11'h2FF},
        {1'b1, 1'b1, 1'b0, 11'h400},
        {1'b0, 1'b0, 1'b1, 11'h7C3},
        {1'b0, 1'b1, 1'b0, 11'h001}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [10:0] w);
        wr_en = 1'b1; wr_data = w[7:0]; wr_err = w[10:8];
        step();
        wr_en = 1'b0;
    endtask

    task automatic take();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rts_n", rts_n, 1);
        check("R11 flag", rts_flag, 0);
        check("R11 overrun", overrun, 0);
        check("R11 trig", trig_irq, 0);
        check("R11 rd_data", rd_data, 0);
        rst_n = 1'b1;
        fifo_en = 1'b1;
        step();

        // R6 table walk: rts mode per vector, plus a word written
        for (int i = 0; i < NV; i++) begin
            auto_rts_en = VEC[i][13];
            rts_req     = VEC[i][12];
            put(VEC[i][10:0]);
            check("R6 rts_n table", rts_n, VEC[i][11]);
        end
        // R1 read back in order with error bits
        for (int i = 0; i < NV; i++) begin
            take();
            check("R1 readback", rd_data, VEC[i][10:0]);
        end
        // R4 read from empty keeps data and pointers
        take();
        check("R4 empty read", rd_data, 11'h001);
        put(11'h123);
        take();
        check("R4 pointers held", rd_data, 11'h123);

        // R5 trigger level
        for (int i = 0; i < 15; i++) put(11'(i));
        check("R5 trig at 15", trig_irq, 0);
        put(11'h0FF);
        check("R5 trig at 16", trig_irq, 1);
        take();
        check("R5 trig at 15 after read", trig_irq, 0);

        // R2 flush and ignore writes while disabled
        fifo_en = 1'b0;
        put(11'h3AA);
        check("R2 trig when off", trig_irq, 0);
        fifo_en = 1'b1;
        step();
        take();
        check("R2 empty after flush", rd_data, 11'h000);

        // automatic mode
        enh_en = 1'b1; rts_int_en = 1'b1;
        auto_rts_en = 1'b1; rts_req = 1'b1;
        step();
        check("R8 low when empty", rts_n, 0);
        for (int i = 0; i < 56; i++) put(11'(i));
        check("R7 hold at 56", rts_n, 0);
        check("R9 no flag yet", rts_flag, 0);
        put(11'(56));
        check("R7 pause at 57", rts_n, 1);
        check("R9 flag on rise", rts_flag, 1);
        isr_rd = 1'b1; step(); isr_rd = 1'b0;
        check("R10 clear flag", rts_flag, 0);
        for (int i = 57; i < 64; i++) put(11'(i));
        check("R3 no overrun at full", overrun, 0);
        put(11'h0EE);
        put(11'h0EF);
        check("R3 overrun set", overrun, 1);

        // drain: R1 order, R3 nothing stored past full, R8 resume
        for (int i = 0; i < 64; i++) begin
            take();
            check("R1 drain data", rd_data, 11'(i));
            if (63 - i == 8)  check("R8 hold at 8", rts_n, 1);
            if (63 - i == 7)  check("R8 resume at 7", rts_n, 0);
            if (63 - i == 30) check("R8 hold mid", rts_n, 1);
        end
        take();
        check("R3 dropped words absent", rd_data, 11'(63));
        check("R3 overrun sticky", overrun, 1);
        fifo_en = 1'b0; step(); fifo_en = 1'b1;
        check("R3 overrun cleared by disable", overrun, 0);

        // R9 gating with manual toggles
        auto_rts_en = 1'b0;
        rts_int_en = 1'b0; enh_en = 1'b1;
        rts_req = 1'b1; step(); rts_req = 1'b0; step();
        check("R9 int disabled", rts_flag, 0);
        rts_int_en = 1'b1; enh_en = 1'b0;
        rts_req = 1'b1; step(); rts_req = 1'b0; step();
        check("R9 enh disabled", rts_flag, 0);
        check("R6 manual rise", rts_n, 1);
        enh_en = 1'b1;
        rts_req = 1'b1; step();
        rts_req = 1'b0; isr_rd = 1'b1; step(); isr_rd = 1'b0;
        check("R10 set wins over clear", rts_flag, 1);
        isr_rd = 1'b1; step(); isr_rd = 1'b0;
        check("R10 clear", rts_flag, 0);

        finish_run();
    end
endmodule